// File: doc/BRIEF.md
# Doorbell and Wired Interrupt Aggregator

This block gathers up to 64 interrupt sources into one interrupt line toward an upstream controller. The low-numbered sources come from level wires. The rest are raised by message writes: a device posts a bus write to a fixed doorbell offset, and the data value of that write names the source to raise. Each source has one latched pending bit and one mask bit. The combined line is high whenever some pending bit is not masked.

Software reaches the state through a small 32-bit register bus with separate read and write strobes, a byte address and write data. The pending and mask vectors are each spread over a pair of 32-bit words. A handler reads both pending words, services the lowest set bit and acknowledges it by writing a one to that bit. It repeats until both words read zero. Read data is registered and appears on the clock after the read strobe.

Top module: `irq_doorbell_agg`

## Requirements
- R1: After reset every pending bit is 0, every mask bit is 1, the interrupt output is 0 and the read data is 0.
- R2: The pending word at offset 0x00 holds sources 0 to 31 and the word at 0x04 holds sources 32 to 63, with source n at bit position n mod 32.
- R3: The mask words at 0x20 (sources 0 to 31) and 0x24 (sources 32 to 63) are written and read back as whole words. A mask bit of 1 blocks its source from the output and a 0 lets it through.
- R4: A write to offset 0x30 whose data is a source number below 64 sets the pending bit of that source on the next clock.
- R5: A write to offset 0x30 whose data is 64 or above changes no pending bit.
- R6: A wired source (0 to 20) sets its pending bit on every clock where its input is high, so the bit cannot be cleared while that input stays high.
- R7: Writing a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When a set (a wired input or a doorbell) and a clear reach the same pending bit in the same clock, the bit ends up set.
- R9: The interrupt output is the OR over all sources of (pending AND NOT mask), taken through one register, so it follows the state with one clock of delay.
- R10: Reads of unused or misaligned offsets, including the doorbell offset 0x30, return 0. Writes to unused offsets change nothing. A read of offset 0x30 never sets a pending bit.
- R11: Read data appears on the clock after the read strobe and is 0 on any clock that follows a clock without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wired_irq | input | 21 | Level inputs of the wired sources 0 to 20 |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt line |

## Verification
A wired input can rise in the same clock in which software acknowledges that source in its pending word, so a set and a clear land on one bit together. The bench raises the wire on the same clock as the acknowledge write and also acknowledges while the wire is still held. It then reads the pending word back and expects the bit to be set, and a behavioural model compares the output line and read data on every clock. An acknowledge write that also falls on the clock where an unmask makes the output change shows the one-clock output delay.

// File: rtl/agg_pkg.sv
package agg_pkg;
   localparam int CAUSE_BASE = 'h00;
   localparam int MASK_BASE  = 'h20;
   localparam int DOOR_OFS   = 'h30;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_CAUSE = 2'd1,
      SEL_MASK  = 2'd2,
      SEL_DOOR  = 2'd3
   } agg_kind_e;

   typedef struct packed {
      agg_kind_e  kind;
      logic [1:0] word;
   } agg_sel_t;
endpackage

// File: rtl/agg_regdec.sv
module agg_regdec
   import agg_pkg::*;
#(
   parameter int AW        = 8,
   parameter int NUM_WORDS = 2
) (
   input  logic [AW-1:0] addr,
   output agg_sel_t      sel
);
   localparam logic [AW-5:0] CAUSE_HI = (AW-4)'(CAUSE_BASE >> 4);
   localparam logic [AW-5:0] MASK_HI  = (AW-4)'(MASK_BASE >> 4);
   localparam logic [AW-1:0] DOOR_A   = AW'(DOOR_OFS);

   logic aligned, in_range;

   always_comb begin
      aligned  = (addr[1:0] == 2'b00);
      in_range = (32'(addr[3:2]) < NUM_WORDS);
      sel.word = addr[3:2];
      sel.kind = SEL_NONE;
      if (aligned) begin
         if (addr == DOOR_A)
            sel.kind = SEL_DOOR;
         else if (addr[AW-1:4] == CAUSE_HI && in_range)
            sel.kind = SEL_CAUSE;
         else if (addr[AW-1:4] == MASK_HI && in_range)
            sel.kind = SEL_MASK;
      end
   end
endmodule

// File: rtl/agg_pending.sv
module agg_pending #(
   parameter int NUM_SRC   = 64,
   parameter int NUM_WIRED = 21,
   parameter int DW        = 32,
   parameter int IDXW      = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WIRED-1:0] wired,
   input  logic                 db_fire,
   input  logic [IDXW-1:0]      db_idx,
   input  logic                 clr_fire,
   input  logic [1:0]           clr_word,
   input  logic [DW-1:0]        clr_data,
   output logic [NUM_SRC-1:0]   pend
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic set_i, clr_i;
      if (i < NUM_WIRED) begin : g_wired
         assign set_i = wired[i] | (db_fire && db_idx == IDXW'(i));
      end else begin : g_msg
         assign set_i = db_fire && db_idx == IDXW'(i);
      end
      assign clr_i = clr_fire && clr_word == 2'(i / DW) && clr_data[i % DW];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pend[i] <= 1'b0;
         else if (set_i)  pend[i] <= 1'b1;
         else if (clr_i)  pend[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/agg_mask.sv
module agg_mask #(
   parameter int NUM_SRC = 64,
   parameter int DW      = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_fire,
   input  logic [1:0]         wr_word,
   input  logic [DW-1:0]      wr_data,
   output logic [NUM_SRC-1:0] mask
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask[i] <= 1'b1;
         else if (wr_fire && wr_word == 2'(i / DW))
            mask[i] <= wr_data[i % DW];
      end
   end
endmodule

// File: rtl/agg_irq_reduce.sv
module agg_irq_reduce #(
   parameter int NUM_SRC = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] mask,
   output logic               irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(pend & ~mask);
   end
endmodule

// File: rtl/irq_doorbell_agg.sv
module irq_doorbell_agg
   import agg_pkg::*;
#(
   parameter int NUM_SRC   = 64,
   parameter int NUM_WIRED = 21,
   parameter int DW        = 32,
   parameter int AW        = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WIRED-1:0] wired_irq,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [AW-1:0]        bus_addr,
   input  logic [DW-1:0]        bus_wdata,
   output logic [DW-1:0]        bus_rdata,
   output logic                 irq_out
);
   localparam int NUM_WORDS = (NUM_SRC + DW - 1) / DW;
   localparam int PADW      = NUM_WORDS * DW;
   localparam int IDXW      = $clog2(NUM_SRC);

   if (NUM_WORDS > 4) begin : g_chk_words
      $error("NUM_SRC needs more than four words per register group");
   end
   if (NUM_WIRED < 1 || NUM_WIRED > NUM_SRC) begin : g_chk_wired
      $error("NUM_WIRED must lie in 1..NUM_SRC");
   end
   if (DW != 32 || AW < 6) begin : g_chk_bus
      $error("register bus must be 32 bits wide with at least 6 address bits");
   end

   agg_sel_t           sel;
   logic [NUM_SRC-1:0] pend_q, mask_q;
   logic               db_fire, clr_fire, mask_fire;
   logic [PADW-1:0]    pend_pad, mask_pad;

   agg_regdec #(.AW(AW), .NUM_WORDS(NUM_WORDS)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign db_fire   = bus_wr && sel.kind == SEL_DOOR && bus_wdata < DW'(NUM_SRC);
   assign clr_fire  = bus_wr && sel.kind == SEL_CAUSE;
   assign mask_fire = bus_wr && sel.kind == SEL_MASK;

   agg_pending #(.NUM_SRC(NUM_SRC), .NUM_WIRED(NUM_WIRED), .DW(DW), .IDXW(IDXW)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .wired    (wired_irq),
      .db_fire  (db_fire),
      .db_idx   (bus_wdata[IDXW-1:0]),
      .clr_fire (clr_fire),
      .clr_word (sel.word),
      .clr_data (bus_wdata),
      .pend     (pend_q)
   );

   agg_mask #(.NUM_SRC(NUM_SRC), .DW(DW)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fire (mask_fire),
      .wr_word (sel.word),
      .wr_data (bus_wdata),
      .mask    (mask_q)
   );

   agg_irq_reduce #(.NUM_SRC(NUM_SRC)) u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .pend (pend_q),
      .mask (mask_q),
      .irq  (irq_out)
   );

   assign pend_pad = PADW'(pend_q);
   assign mask_pad = PADW'(mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         unique case (sel.kind)
            SEL_CAUSE: bus_rdata <= pend_pad[32'(sel.word)*DW +: DW];
            SEL_MASK:  bus_rdata <= mask_pad[32'(sel.word)*DW +: DW];
            default:   bus_rdata <= '0;
         endcase
      end else begin
         bus_rdata <= '0;
      end
   end
endmodule

// File: rtl/agg_checker.sv
module agg_checker #(
   parameter int NUM_SRC   = 64,
   parameter int NUM_WIRED = 21,
   parameter int DW        = 32,
   parameter int AW        = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_WIRED-1:0] wired_irq,
   input logic                 bus_wr,
   input logic                 bus_rd,
   input logic [AW-1:0]        bus_addr,
   input logic [DW-1:0]        bus_wdata,
   input logic [DW-1:0]        bus_rdata,
   input logic                 irq_out,
   input logic [NUM_SRC-1:0]   pend_q,
   input logic [NUM_SRC-1:0]   mask_q
);
   localparam int IDXW = $clog2(NUM_SRC);
   localparam logic [AW-1:0] DOOR_A  = AW'('h30);
   localparam logic [AW-1:0] MASK_A0 = AW'('h20);
   localparam logic [AW-1:0] MASK_A1 = AW'('h24);

   logic db_wr, mask_wr;
   assign db_wr   = bus_wr && bus_addr == DOOR_A;
   assign mask_wr = bus_wr && (bus_addr == MASK_A0 || bus_addr == MASK_A1);

   AST_DOORBELL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (db_wr && bus_wdata < DW'(NUM_SRC)) |=> pend_q[$past(bus_wdata[IDXW-1:0])]); // R4

   AST_DOORBELL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (db_wr && bus_wdata >= DW'(NUM_SRC)) |=> pend_q[NUM_SRC-1:NUM_WIRED] == $past(pend_q[NUM_SRC-1:NUM_WIRED])); // R5

   AST_WIRED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wired_irq != '0) |=> ((pend_q[NUM_WIRED-1:0] & $past(wired_irq)) == $past(wired_irq))); // R6

   AST_MASK_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(mask_q)); // R10

   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_q & ~mask_q)) |=> irq_out); // R9

   AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(pend_q & ~mask_q)) |=> !irq_out); // R9

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> bus_rdata == '0); // R11
endmodule

bind irq_doorbell_agg agg_checker #(
   .NUM_SRC(NUM_SRC), .NUM_WIRED(NUM_WIRED), .DW(DW), .AW(AW)
) u_agg_chk (
   .clk(clk), .rst_n(rst_n), .wired_irq(wired_irq), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .irq_out(irq_out), .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/irq_doorbell_agg_test.sv
`timescale 1ns/1ps
module irq_doorbell_agg_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [20:0] wired_irq = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int n_tests = 0, n_fail = 0, cycles = 0;
   bit done = 0;

   // behavioural reference state
   bit [63:0] m_pend = '0, m_mask = '1;
   bit        m_irq = 0;
   bit [31:0] m_rd = '0;

   always #5 clk = ~clk;

   irq_doorbell_agg uut (
      .clk(clk), .rst_n(rst_n), .wired_irq(wired_irq), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // reference model, compared on every clock
   always @(posedge clk) begin
      bit [63:0] np;
      if (!rst_n) begin
         m_pend = '0; m_mask = '1; m_irq = 0; m_rd = '0;
      end else begin
         m_irq = |(m_pend & ~m_mask);
         m_rd = '0;
         if (bus_rd) begin
            case (bus_addr)
               8'h00: m_rd = m_pend[31:0];
               8'h04: m_rd = m_pend[63:32];
               8'h20: m_rd = m_mask[31:0];
               8'h24: m_rd = m_mask[63:32];
               default: m_rd = '0;
            endcase
         end
         np = m_pend;
         if (bus_wr) begin
            case (bus_addr)
               8'h00: np = np & ~{32'h0, bus_wdata};
               8'h04: np = np & ~{bus_wdata, 32'h0};
               8'h20: m_mask[31:0] = bus_wdata;
               8'h24: m_mask[63:32] = bus_wdata;
               8'h30: if (bus_wdata < 64) np[bus_wdata] = 1'b1;
               default: ;
            endcase
         end
         for (int i = 0; i < 21; i++) if (wired_irq[i]) np[i] = 1'b1;
         m_pend = np;
      end
      #2;
      if (!done) begin
         check(irq_out === m_irq, "R9 model irq", longint'(irq_out), longint'(m_irq));
         check(bus_rdata === m_rd, "R11 model rdata", longint'(bus_rdata), longint'(m_rd));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
         finish_run();
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1; bus_addr = a;
      @(posedge clk); #2 d = bus_rdata;
      @(negedge clk); bus_rd = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      idle(1);
      // R1 reset state
      check(irq_out == 0, "R1 irq", irq_out, 0);
      check(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
      rd(8'h00, d); check(d == 0, "R1 cause0", d, 0);
      rd(8'h04, d); check(d == 0, "R1 cause1", d, 0);
      rd(8'h20, d); check(d == 32'hFFFF_FFFF, "R1 mask0", d, 32'hFFFF_FFFF);
      rd(8'h24, d); check(d == 32'hFFFF_FFFF, "R1 mask1", d, 32'hFFFF_FFFF);

      // R4 doorbell for source 40 lands in word 1 bit 8 (R2)
      wr(8'h30, 32'd40);
      rd(8'h04, d); check(d == 32'h100, "R4 R2 source40", d, 32'h100);
      check(irq_out == 0, "R3 masked source silent", irq_out, 0);

      // R9 unmask: output follows one clock later
      wr(8'h24, 32'hFFFF_FEFF);
      check(irq_out == 0, "R9 no same-edge change", irq_out, 0);
      @(posedge clk); #2;
      check(irq_out == 1, "R9 one clock later", irq_out, 1);
      rd(8'h24, d); check(d == 32'hFFFF_FEFF, "R3 mask readback", d, 32'hFFFF_FEFF);

      // R5 out-of-range doorbells
      wr(8'h30, 32'd64);
      wr(8'h30, 32'h1000_0015);
      rd(8'h00, d); check(d == 0, "R5 word0 untouched", d, 0);
      rd(8'h04, d); check(d == 32'h100, "R5 word1 untouched", d, 32'h100);

      // R7 write-one-to-clear
      wr(8'h04, 32'h0);
      rd(8'h04, d); check(d == 32'h100, "R7 zero write keeps", d, 32'h100);
      wr(8'h04, 32'h100);
      rd(8'h04, d); check(d == 0, "R7 one write clears", d, 0);
      idle(2);
      check(irq_out == 0, "R9 drops after clear", irq_out, 0);

      // R6 wired level source 3
      @(negedge clk); wired_irq[3] = 1;
      idle(2);
      rd(8'h00, d); check(d[3] == 1, "R6 wired sets", d[3], 1);
      wr(8'h00, 32'h8);
      rd(8'h00, d); check(d[3] == 1, "R6 clear blocked while high", d[3], 1);
      @(negedge clk); wired_irq[3] = 0;
      wr(8'h00, 32'h8);
      rd(8'h00, d); check(d[3] == 0, "R6 clear after release", d[3], 0);

      // R8 wired rise and clear on the same clock
      @(negedge clk); wired_irq[7] = 1; bus_wr = 1; bus_addr = 8'h00; bus_wdata = 32'h80;
      @(negedge clk); bus_wr = 0; wired_irq[7] = 0;
      rd(8'h00, d); check(d[7] == 1, "R8 set wins", d[7], 1);
      wr(8'h00, 32'h80);
      rd(8'h00, d); check(d[7] == 0, "R8 later clear", d[7], 0);

      // R10 unused offsets and doorbell reads
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h28, 32'h0);
      wr(8'h22, 32'h0);
      rd(8'h10, d); check(d == 0, "R10 unused read", d, 0);
      rd(8'h08, d); check(d == 0, "R10 unused read 08", d, 0);
      rd(8'h24, d); check(d == 32'hFFFF_FEFF, "R10 mask unchanged", d, 32'hFFFF_FEFF);
      rd(8'h20, d); check(d == 32'hFFFF_FFFF, "R10 mask0 unchanged", d, 32'hFFFF_FFFF);
      bus_wdata = 32'd21;
      rd(8'h30, d); check(d == 0, "R10 doorbell reads zero", d, 0);
      rd(8'h00, d); check(d[21] == 0, "R10 read no doorbell", d[21], 0);

      // R4 R2 boundary sources
      wr(8'h30, 32'd63);
      wr(8'h30, 32'd21);
      wr(8'h30, 32'd0);
      rd(8'h04, d); check(d == 32'h8000_0000, "R2 source63", d, 32'h8000_0000);
      rd(8'h00, d); check(d == 32'h0020_0001, "R4 sources 21 and 0", d, 32'h0020_0001);
      wr(8'h20, 32'hFFFF_FFFE);
      idle(2);
      check(irq_out == 1, "R3 unmasked source0", irq_out, 1);
      idle(1);
      check(bus_rdata == 0, "R11 idle rdata", bus_rdata, 0);

      idle(2);
      done = 1;
      finish_run();
   end
endmodule